// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block produces the two external-memory strobes of an 8051-style controller: the address-latch pulse (`ale`, active high) and the program-read strobe (`psen_n`, active low). It divides the oscillator clock into machine cycles of 12 clocks and reports the position inside the cycle on `phase`. It also takes the access type of each machine cycle from the core and picks the strobe pattern from it: an internal fetch, an external fetch, an external data move or a code-table read.

The address latch normally pulses twice in each machine cycle, so it runs at one sixth of the oscillator rate. A software-controlled disable bit can stop these pulses, and the pin then rests weakly high. The disable bit has no effect on external fetches, data moves and table reads. An external data move drops the second latch pulse and both read-strobe pulses. In idle the phase counter keeps running and both strobes sit high. In power-down the counter stops and both strobes sit low, and only a reset ends this state. A reset is accepted only after the reset pin has been high for two whole machine cycles.

The controller has four states. `ST_RESET` leads to `ST_RUN` through *release*. At the end of a machine cycle, *sleep* takes `ST_RUN` to `ST_IDLE`, *wake* takes `ST_IDLE` back to `ST_RUN`, and *halt* takes `ST_RUN` or `ST_IDLE` to `ST_PDOWN`. *Qualified reset* takes any state to `ST_RESET`.

Top module: `xbus_strobe_gen`

## Requirements
- R1: A reset takes effect only once `rst_pin` has been sampled high on 24 consecutive clocks (two machine cycles). A shorter pulse has no effect on the outputs or the state, and this includes power-down.
- R2: In reset, `ale`=1, `ale_strong`=1, `psen_n`=1 and `phase`=0. After the reset pin is released, the first machine cycle begins with `phase`=0.
- R3: `phase` counts 0 to 11 and then wraps to 0. `acc_type` is latched only on the clock edge that ends phase 11, so a change in the middle of a cycle has no effect on that cycle's strobes.
- R4: Internal fetch (`acc_type`=0) with `ale_off`=0: `ale` is high at phases 0–1 and 6–7, and `psen_n` stays high.
- R5: External fetch (`acc_type`=1): `ale` is high at phases 0–1 and 6–7, and `psen_n` is low at phases 3–5 and 9–11.
- R6: External data move (`acc_type`=2): `ale` is high only at phases 0–1, and `psen_n` stays high for the whole cycle.
- R7: With `ale_off`=1 during an internal fetch, `ale`=1 and `ale_strong`=0 (weak pull-up) for the whole cycle, and `psen_n` stays high.
- R8: `ale_off` has no effect on the patterns for external fetch, external data move and code-table read.
- R9: Code-table read (`acc_type`=3) produces the external-fetch pattern of R5.
- R10: With `idle_req` high at the end of a cycle, the block enters idle from the next cycle. In idle, `ale`=1, `psen_n`=1, both strongly driven, and `phase` keeps counting. Idle ends at the first cycle end where `idle_req` is low.
- R11: With `pdown_req` high at the end of a cycle, the block enters power-down. Power-down takes priority over idle. In power-down, `ale`=0, `psen_n`=0 and `phase` is frozen at 0. Only a qualified reset leaves this state.
- R12: `psen_n` is never low while `ale` is strongly driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| acc_type | input | 2 | Access type for the next machine cycle (0 internal fetch, 1 external fetch, 2 external data, 3 table read) |
| ale_off | input | 1 | Latch-pulse disable control bit |
| idle_req | input | 1 | Idle mode flag |
| pdown_req | input | 1 | Power-down mode flag |
| ale | output | 1 | Address latch strobe level |
| ale_strong | output | 1 | 1 when `ale` is driven strongly, 0 when it rests on the weak pull-up |
| psen_n | output | 1 | Program read strobe, active low |
| phase | output | 4 | Clock position inside the machine cycle, 0 to 11 |

## Verification
The assertions check every cycle that the read strobe never overlaps an active latch pulse, that the phase count steps or wraps correctly and stays in range, and that the count is frozen in power-down. They also check that idle holds both strobes high, that only fetch-type cycles pulse the read strobe, and that a qualified reset always follows a high pin. The bench scenarios are needed for the rest: the exact phase positions of each pattern, that a mid-cycle access-type change is ignored, the 23-versus-24 clock reset boundary, that power-down cannot be left without a reset, and that the disable bit has no effect on external cycles.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    typedef enum logic [1:0] {
        ACC_INT    = 2'd0,
        ACC_XFETCH = 2'd1,
        ACC_XDATA  = 2'd2,
        ACC_TABLE  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_RUN   = 2'd1,
        ST_IDLE  = 2'd2,
        ST_PDOWN = 2'd3
    } bus_st_e;

endpackage

// File: rtl/xbs_rst_qual.sv
module xbs_rst_qual #(
    parameter int HOLD = 24
) (
    input  logic clk,
    input  logic rst_pin,
    output logic rst_ok
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] hi_cnt;

    // count consecutive high samples, saturating at HOLD
    always_ff @(posedge clk) begin
        if (!rst_pin)
            hi_cnt <= '0;
        else if (hi_cnt != CW'(HOLD))
            hi_cnt <= hi_cnt + 1'b1;
    end

    assign rst_ok = (hi_cnt == CW'(HOLD));

    assert_reset_needs_pin_R1: assert property (@(posedge clk)
        rst_ok |-> $past(rst_pin));

endmodule

// File: rtl/xbs_phase_ctr.sv
module xbs_phase_ctr #(
    parameter int LEN = 12,
    parameter int PW  = 4
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en,
    output logic [PW-1:0] phase,
    output logic          last
);
    assign last = (phase == PW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (clr)
            phase <= '0;
        else if (en)
            phase <= last ? '0 : phase + 1'b1;
    end

    assert_phase_step_R3: assert property (@(posedge clk) disable iff (clr)
        en |=> (phase == '0 || phase == $past(phase) + 1'b1));

    assert_phase_range_R3: assert property (@(posedge clk) disable iff (clr)
        phase < PW'(LEN));

endmodule

// File: rtl/xbs_strobe_fsm.sv
module xbs_strobe_fsm
    import xbs_pkg::*;
#(
    parameter int LEN   = 12,
    parameter int PW    = 4,
    parameter int ALE_W = 2,
    parameter int PS_W  = 3
) (
    input  logic          clk,
    input  logic          rst_ok,
    input  logic [PW-1:0] phase,
    input  logic          last,
    input  logic [1:0]    acc_type,
    input  logic          ale_off,
    input  logic          idle_req,
    input  logic          pdown_req,
    output logic          ctr_en,
    output logic          ale,
    output logic          ale_strong,
    output logic          psen_n
);
    localparam int HALF   = LEN / 2;
    localparam int PS_OFF = ALE_W + 1;

    bus_st_e state, state_nx;
    acc_e    acc_q;

    logic          in_first;
    logic [PW-1:0] half_off;
    logic          ale_slot;
    logic          ps_slot;

    assign ctr_en = (state == ST_RUN) || (state == ST_IDLE);

    // next-state logic: mode changes only at a machine-cycle boundary
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RESET: state_nx = ST_RUN;                   // release
            ST_RUN: begin
                if (last && pdown_req)     state_nx = ST_PDOWN; // halt
                else if (last && idle_req) state_nx = ST_IDLE;  // sleep
            end
            ST_IDLE: begin
                if (last && pdown_req)      state_nx = ST_PDOWN; // halt
                else if (last && !idle_req) state_nx = ST_RUN;   // wake
            end
            ST_PDOWN: state_nx = ST_PDOWN;
        endcase
    end

    // state register and access-type latch
    always_ff @(posedge clk) begin
        if (rst_ok)
            state <= ST_RESET;                             // qualified reset
        else
            state <= state_nx;
        if (state == ST_RESET || (ctr_en && last))
            acc_q <= acc_e'(acc_type);
    end

    assign in_first = (phase < PW'(HALF));
    assign half_off = in_first ? phase : phase - PW'(HALF);
    assign ale_slot = (half_off < PW'(ALE_W));
    assign ps_slot  = (half_off >= PW'(PS_OFF)) && (half_off < PW'(PS_OFF + PS_W));

    // output logic
    always_comb begin
        ale        = 1'b0;
        ale_strong = 1'b1;
        psen_n     = 1'b1;
        unique case (state)
            ST_RESET, ST_IDLE: ale = 1'b1;
            ST_PDOWN: begin
                ale    = 1'b0;
                psen_n = 1'b0;
            end
            ST_RUN: begin
                unique case (acc_q)
                    ACC_INT: begin
                        if (ale_off) begin
                            ale        = 1'b1;
                            ale_strong = 1'b0;
                        end else begin
                            ale = ale_slot;
                        end
                    end
                    ACC_XFETCH, ACC_TABLE: begin
                        ale    = ale_slot;
                        psen_n = !ps_slot;
                    end
                    ACC_XDATA: ale = ale_slot && in_first;
                endcase
            end
        endcase
    end

    assert_psen_fetch_only_R6: assert property (@(posedge clk) disable iff (rst_ok)
        (state == ST_RUN && !psen_n) |-> (acc_q == ACC_XFETCH || acc_q == ACC_TABLE));

    assert_idle_pins_R10: assert property (@(posedge clk) disable iff (rst_ok)
        (state == ST_IDLE) |-> (ale && psen_n && ale_strong));

    assert_pdown_freeze_R11: assert property (@(posedge clk) disable iff (rst_ok)
        (state == ST_PDOWN) |=> $stable(phase));

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen #(
    parameter int CYC_LEN    = 12,
    parameter int RST_CYCLES = 2,
    parameter int ALE_W      = 2,
    parameter int PSEN_W     = 3,
    localparam int PH_W      = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_pin,
    input  logic [1:0]      acc_type,
    input  logic            ale_off,
    input  logic            idle_req,
    input  logic            pdown_req,
    output logic            ale,
    output logic            ale_strong,
    output logic            psen_n,
    output logic [PH_W-1:0] phase
);
    localparam int HOLD = CYC_LEN * RST_CYCLES;

    logic rst_ok;
    logic ctr_en;
    logic last;

    xbs_rst_qual #(.HOLD(HOLD)) u_rst (
        .clk     (clk),
        .rst_pin (rst_pin),
        .rst_ok  (rst_ok)
    );

    xbs_phase_ctr #(.LEN(CYC_LEN), .PW(PH_W)) u_ctr (
        .clk   (clk),
        .clr   (rst_ok),
        .en    (ctr_en),
        .phase (phase),
        .last  (last)
    );

    xbs_strobe_fsm #(.LEN(CYC_LEN), .PW(PH_W), .ALE_W(ALE_W), .PS_W(PSEN_W)) u_fsm (
        .clk        (clk),
        .rst_ok     (rst_ok),
        .phase      (phase),
        .last       (last),
        .acc_type   (acc_type),
        .ale_off    (ale_off),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .ctr_en     (ctr_en),
        .ale        (ale),
        .ale_strong (ale_strong),
        .psen_n     (psen_n)
    );

    assert_no_overlap_R12: assert property (@(posedge clk)
        !(ale && ale_strong && !psen_n));

    assert_reset_phase_R2: assert property (@(posedge clk)
        rst_ok |=> (phase == '0));

endmodule

// File: tb/xbus_strobe_gen_tb_top.sv
module xbus_strobe_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_pin;
    logic [1:0] acc_type;
    logic       ale_off;
    logic       idle_req;
    logic       pdown_req;
    logic       ale;
    logic       ale_strong;
    logic       psen_n;
    logic [3:0] phase;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  a;
        logic  s;
        logic  p;
        int    ph;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    xbus_strobe_gen dut_i (
        .clk        (clk),
        .rst_pin    (rst_pin),
        .acc_type   (acc_type),
        .ale_off    (ale_off),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .ale        (ale),
        .ale_strong (ale_strong),
        .psen_n     (psen_n),
        .phase      (phase)
    );

    task automatic check(input bit ok, input string req, input string act, input string expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s at %0t", req, act, expv, $time);
        end
    endtask

    function automatic exp_t model(input logic [1:0] a, input logic off, input logic idl,
                                   input logic pd, input int ph, input logic glitch);
        exp_t e;
        int   o;
        logic first, aslot, pslot;
        o     = ph % 6;
        first = (ph < 6);
        aslot = (o < 2);
        pslot = (o >= 3) && (o < 6);
        e.ph  = ph;
        e.s   = 1'b1;
        e.p   = 1'b1;
        if (pd) begin
            e.a = 1'b0; e.p = 1'b0; e.ph = 0; e.tag = "R11";
        end else if (idl) begin
            e.a = 1'b1; e.tag = "R10";
        end else begin
            unique case (a)
                2'd0: begin
                    if (off) begin e.a = 1'b1; e.s = 1'b0; e.tag = "R7"; end
                    else begin e.a = aslot; e.tag = "R4"; end
                end
                2'd1: begin e.a = aslot; e.p = !pslot; e.tag = off ? "R8" : "R5"; end
                2'd2: begin e.a = aslot && first; e.tag = off ? "R8" : "R6"; end
                2'd3: begin e.a = aslot; e.p = !pslot; e.tag = "R9"; end
            endcase
        end
        if (glitch) e.tag = {e.tag, "/R3"};
        return e;
    endfunction

    // driver: sets the next cycle's inputs at the last phase and queues its expected samples
    task automatic run_cycle(input logic [1:0] a, input logic off, input logic idl,
                             input logic pd, input logic glitch);
        @(negedge clk);
        while (phase != 4'd11) @(negedge clk);
        acc_type  = a;
        ale_off   = off;
        idle_req  = idl;
        pdown_req = pd;
        for (int i = 0; i < 12; i++) sb_q.push_back(model(a, off, idl, pd, i, glitch));
        if (glitch) begin
            repeat (5) @(negedge clk);
            acc_type = ~a;
        end
    endtask

    task automatic smp();
        @(posedge clk);
        #3;
    endtask

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check({ale, ale_strong, psen_n} == {e.a, e.s, e.p}, e.tag,
                      $sformatf("ale/strong/psen_n=%b%b%b ph=%0d", ale, ale_strong, psen_n, phase),
                      $sformatf("%b%b%b ph=%0d", e.a, e.s, e.p, e.ph));
                check(int'(phase) == e.ph, {e.tag, "/R3"}, $sformatf("%0d", phase), $sformatf("%0d", e.ph));
                check(!(ale && ale_strong && !psen_n), "R12",
                      $sformatf("ale=%b psen_n=%b", ale, psen_n), "no overlap");
            end
        end
    end

    initial begin
        rst_pin = 1'b1; acc_type = 2'd0; ale_off = 1'b0; idle_req = 1'b0; pdown_req = 1'b0;
        repeat (30) smp();
        check(ale && ale_strong && psen_n && phase == 0, "R2",
              $sformatf("%b%b%b ph=%0d", ale, ale_strong, psen_n, phase), "111 ph=0");
        @(negedge clk) rst_pin = 1'b0;
        smp();
        smp();
        check(phase == 0, "R2", $sformatf("%0d", phase), "0");
        smp();
        check(phase == 1, "R2", $sformatf("%0d", phase), "1");

        run_cycle(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);  // R4
        run_cycle(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);  // R5
        run_cycle(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);  // R6
        run_cycle(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);  // R9
        run_cycle(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);  // R7
        run_cycle(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);  // R8
        run_cycle(2'd2, 1'b1, 1'b0, 1'b0, 1'b0);  // R8
        run_cycle(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);  // R9 with R8
        run_cycle(2'd1, 1'b0, 1'b0, 1'b0, 1'b1);  // R3 mid-cycle change
        run_cycle(2'd2, 1'b0, 1'b0, 1'b0, 1'b1);  // R3
        run_cycle(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);  // R10 idle
        run_cycle(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);  // R10 stays idle
        run_cycle(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);  // R10 wake
        run_cycle(2'd0, 1'b0, 1'b1, 1'b1, 1'b0);  // R11 pdown beats idle
        repeat (13) smp();

        @(negedge clk) begin pdown_req = 1'b0; idle_req = 1'b0; end
        repeat (5) smp();
        check(!ale && !psen_n && phase == 0, "R11",
              $sformatf("ale=%b psen_n=%b ph=%0d", ale, psen_n, phase), "ale=0 psen_n=0 ph=0");

        @(negedge clk) rst_pin = 1'b1;
        repeat (23) @(posedge clk);
        @(negedge clk) rst_pin = 1'b0;
        repeat (3) smp();
        check(!ale && !psen_n && phase == 0, "R1",
              $sformatf("ale=%b psen_n=%b", ale, psen_n), "23-clock pulse ignored: 0 0");

        @(negedge clk) rst_pin = 1'b1;
        repeat (30) smp();
        check(ale && ale_strong && psen_n && phase == 0, "R1",
              $sformatf("%b%b%b ph=%0d", ale, ale_strong, psen_n, phase), "111 ph=0");
        @(negedge clk) rst_pin = 1'b0;
        run_cycle(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);  // R5 after reset
        run_cycle(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);  // R4
        repeat (14) smp();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule